// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a large field of peripheral event wires and a processor core with sixteen interrupt positions. The two highest positions are fixed: position 0 is a reset request and position 1 is a non-maskable request, each fed by its own input pin. Positions 2 and 3 are reserved and never reach the core. Positions 4 to 15 are maskable lines. Each has a selector register that names which of the 128 event wires drives it.

A rising edge on a routed event latches a flag bit for its line. This happens whatever the enable settings are. A flag turns into a request only when the gating allows it. A maskable line needs its own enable bit, the global enable and the non-maskable enable. The non-maskable line needs only the non-maskable enable. The reset line is never gated. Among the requests that survive gating, the lowest position wins. Its 4-bit number is shown on the vector output, and the request output is raised. When the core acknowledges, the block clears the granted flag. It also copies the global enable into a saved bit and clears the global enable, so nothing else can interrupt until software writes it back.

A single write port reaches every register: the control word, the enable word, the flag-set and flag-clear strobes, and the twelve selectors.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The position numbers are 0 to 15. Among the pending positions that survive gating, the lowest number wins. While any position survives, irq_o is 1 and vec_o holds the winner's 4-bit number. With no flags set after reset, irq_o is 0.
- R2: A write to address n (n from 4 to 15) loads wr_data_i[6:0] as the event number for line n. A rising edge on that event wire sets flag n.
- R3: A flag is set by its event even while the line is disabled. If the line is enabled later, the request appears.
- R4: A maskable line n is requested only when all three enables are 1: enable bit n (address 1, bit n), the global enable (address 0, bit 0) and the non-maskable enable (address 0, bit 1).
- R5: A rising edge on nmi_evt_i sets flag 1. That flag is requested when the non-maskable enable is 1, whatever the enable word and the global enable hold.
- R6: A rising edge on rst_evt_i sets flag 0. That flag is always requested and wins over every other position.
- R7: Flags 2 and 3 can be set, but they never produce a request.
- R8: When ack_i is 1 while irq_o is 1, at that clock edge the flag at vec_o is cleared, the global enable is copied into a saved bit, and the global enable is cleared. A control write with bit 3 set reloads the global enable from the saved bit and leaves the other control bits unchanged.
- R9: An event that stays high sets its flag only once. An event that is already high when it is selected does not set the flag.
- R10: Writing to address 2 sets every flag whose data bit is 1. Writing to address 3 clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R11: Routing event 61 to line 5 and setting enable bit 5, with both global enables set, delivers vector 5 when event 61 rises.
- R12: ack_i has no effect while irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 128 | Peripheral event wires |
| rst_evt_i | input | 1 | Reset request, drives position 0 |
| nmi_evt_i | input | 1 | Non-maskable request, drives position 1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address: 0 control, 1 enable, 2 flag set, 3 flag clear, 4-15 selectors |
| wr_data_i | input | 16 | Register write data |
| ack_i | input | 1 | Acknowledge from the core |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 4 | Number of the winning position |

## Verification
The bench sets several flags at once and acknowledges them one at a time. A priority encoder that picked the highest index, or that did not clear the granted flag, would give the wrong order. It toggles the global enable and the non-maskable enable separately. A design that skipped either gate, or that wrongly applied the maskable gates to position 1, would show a request where none is expected, or miss one. It holds an event high across an acknowledge and across a selector change. A level-sensitive flag would fire again. It also sets the reserved flags, acknowledges with no request present, and stacks reset on top of the non-maskable request and a maskable one. Leaking reserved lines, a stray acknowledge that clears the global enable, or a broken restore of the saved enable all show up at the ports.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  // register addresses; 4 and up select a line's event
  localparam int unsigned IVC_A_CTRL   = 0;
  localparam int unsigned IVC_A_ENABLE = 1;
  localparam int unsigned IVC_A_FSET   = 2;
  localparam int unsigned IVC_A_FCLR   = 3;
  // control word bits
  localparam int unsigned IVC_B_GIE     = 0;
  localparam int unsigned IVC_B_NMIE    = 1;
  localparam int unsigned IVC_B_RESTORE = 3;
endpackage

// File: rtl/ivc_edge.sv
module ivc_edge #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // a held level produces one pulse only (R9)
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/ivc_route.sv
module ivc_route #(
  parameter int unsigned NUM_EVENTS = 128,
  parameter int unsigned SEL_W      = 7,
  parameter int unsigned LINES      = 12
) (
  input  logic [NUM_EVENTS-1:0] rise_i,
  input  logic [SEL_W-1:0]      sel_i [LINES],
  output logic [LINES-1:0]      line_rise_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    assign line_rise_o[l] = rise_i[sel_i[l]];
  end
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
  parameter int unsigned LINES = 16,
  localparam int unsigned VEC_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] pend_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  // lowest set index wins
  function automatic logic [VEC_W-1:0] lowest_pending(input logic [LINES-1:0] p);
    lowest_pending = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (p[i]) lowest_pending = VEC_W'(i);
    end
  endfunction

  assign irq_o = |pend_i;
  assign vec_o = lowest_pending(pend_i);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl import ivc_pkg::*; #(
  parameter int unsigned NUM_EVENTS     = 128,
  parameter int unsigned NUM_LINES      = 16,
  parameter int unsigned FIRST_MASKABLE = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_EVENTS-1:0]        evt_i,
  input  logic                         rst_evt_i,
  input  logic                         nmi_evt_i,
  input  logic                         wr_en_i,
  input  logic [$clog2(NUM_LINES)-1:0] wr_addr_i,
  input  logic [NUM_LINES-1:0]         wr_data_i,
  input  logic                         ack_i,
  output logic                         irq_o,
  output logic [$clog2(NUM_LINES)-1:0] vec_o
);
  localparam int unsigned VEC_W  = $clog2(NUM_LINES);
  localparam int unsigned SEL_W  = $clog2(NUM_EVENTS);
  localparam int unsigned MASK_N = NUM_LINES - FIRST_MASKABLE;

  logic [NUM_EVENTS-1:0] evt_rise;
  logic [1:0]            top_rise;
  logic [MASK_N-1:0]     line_rise;
  logic [SEL_W-1:0]      sel_q [MASK_N];
  logic [MASK_N-1:0]     enable_q;
  logic                  gie_q, nmie_q, pgie_q;
  logic [NUM_LINES-1:0]  flag_q, flag_d, hw_set, sw_set, sw_clr, ack_mask, pend;
  logic                  wr_ctrl, wr_enable, ack_hit;

  ivc_edge #(.W(NUM_EVENTS)) u_evt_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(evt_i), .rise_o(evt_rise));

  ivc_edge #(.W(2)) u_top_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i({nmi_evt_i, rst_evt_i}), .rise_o(top_rise));

  ivc_route #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W), .LINES(MASK_N)) u_route (
    .rise_i(evt_rise), .sel_i(sel_q), .line_rise_o(line_rise));

  ivc_prio #(.LINES(NUM_LINES)) u_prio (
    .pend_i(pend), .irq_o(irq_o), .vec_o(vec_o));

  // write decode
  assign wr_ctrl   = wr_en_i && (wr_addr_i == VEC_W'(IVC_A_CTRL));
  assign wr_enable = wr_en_i && (wr_addr_i == VEC_W'(IVC_A_ENABLE));
  assign sw_set    = (wr_en_i && (wr_addr_i == VEC_W'(IVC_A_FSET))) ? wr_data_i : '0;
  assign sw_clr    = (wr_en_i && (wr_addr_i == VEC_W'(IVC_A_FCLR))) ? wr_data_i : '0;

  // acknowledge of the granted position
  assign ack_hit  = ack_i && irq_o;
  assign ack_mask = ack_hit ? (NUM_LINES'(1) << vec_o) : '0;

  always_comb begin
    hw_set = '0;
    hw_set[0] = top_rise[0];
    hw_set[1] = top_rise[1];
    hw_set[NUM_LINES-1:FIRST_MASKABLE] = line_rise;
  end

  // a new event or software set beats a clear in the same cycle
  assign flag_d = (flag_q & ~sw_clr & ~ack_mask) | sw_set | hw_set;

  // gating per position
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_pend
    if (i == 0) begin : g_reset
      assign pend[i] = flag_q[i];
    end else if (i == 1) begin : g_nmi
      assign pend[i] = flag_q[i] && nmie_q;
    end else if (i < FIRST_MASKABLE) begin : g_resv
      assign pend[i] = 1'b0;
    end else begin : g_mask
      assign pend[i] = flag_q[i] && enable_q[i-FIRST_MASKABLE] && gie_q && nmie_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q   <= '0;
      enable_q <= '0;
      gie_q    <= 1'b0;
      nmie_q   <= 1'b0;
      pgie_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (wr_enable) enable_q <= wr_data_i[NUM_LINES-1:FIRST_MASKABLE];
      if (wr_ctrl && !wr_data_i[IVC_B_RESTORE]) nmie_q <= wr_data_i[IVC_B_NMIE];
      if (ack_hit) begin
        pgie_q <= gie_q;
        gie_q  <= 1'b0;
      end else if (wr_ctrl) begin
        gie_q <= wr_data_i[IVC_B_RESTORE] ? pgie_q : wr_data_i[IVC_B_GIE];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < MASK_N; k++) begin
      if (!rst_n) sel_q[k] <= '0;
      else if (wr_en_i && (int'(wr_addr_i) == FIRST_MASKABLE + k))
        sel_q[k] <= wr_data_i[SEL_W-1:0];
    end
  end

  // reserved positions never reach the core (R7)
  assert_reserved_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o < 2 || int'(vec_o) >= FIRST_MASKABLE));

  // maskable grant needs both global enables (R4)
  assert_mask_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && int'(vec_o) >= FIRST_MASKABLE) |-> (gie_q && nmie_q));

  // non-maskable grant needs its enable (R5)
  assert_nmi_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && vec_o == VEC_W'(1)) |-> nmie_q);

  // acknowledge drops the global enable (R8)
  assert_ack_drops_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> !gie_q);

  // acknowledge clears the granted flag unless re-set at once (R8)
  assert_ack_clears_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !hw_set[vec_o] && !sw_set[vec_o]) |=> !flag_q[$past(vec_o)]);
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] evt = '0;
  logic         rst_evt = 1'b0, nmi_evt = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [15:0]  wr_data = '0;
  logic         ack = 1'b0;
  logic         irq;
  logic [3:0]   vec;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  localparam int LIMIT = 20000;

  logic [4:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .rst_evt_i(rst_evt), .nmi_evt_i(nmi_evt),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ack_i(ack), .irq_o(irq), .vec_o(vec));

  // monitor: compares queued expectations shortly after each edge
  always @(posedge clk) begin
    logic [4:0] e;
    string t;
    #2;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (irq !== e[4] || (e[4] && vec !== e[3:0])) begin
        errors++;
        $display("FAIL %s: actual irq=%0b vec=%0d expected irq=%0b vec=%0d",
                 t, irq, vec, e[4], e[3:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == LIMIT) begin
      errors++;
      $display("FAIL R1 watchdog: actual cycles=%0d expected below %0d", cycles, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // driver tasks
  task automatic expect_out(input bit e_irq, input bit [3:0] e_vec, input string tag);
    @(negedge clk);
    exp_q.push_back({e_irq, e_vec});
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(posedge clk);
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_evt(input int idx);
    @(negedge clk); evt[idx] = 1'b1;
    @(posedge clk);
    @(negedge clk); evt[idx] = 1'b0;
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi_evt = 1'b1;
    @(posedge clk);
    @(negedge clk); nmi_evt = 1'b0;
  endtask

  task automatic pulse_rst();
    @(negedge clk); rst_evt = 1'b1;
    @(posedge clk);
    @(negedge clk); rst_evt = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    expect_out(0, 0, "R1 idle after reset");

    // R11: event 61 to line 5
    wr(5, 61); wr(1, 1 << 5); wr(0, 3);
    pulse_evt(61);
    expect_out(1, 5, "R11 event 61 on line 5");
    // R8: acknowledge clears flag and global enable, restore brings it back
    do_ack();
    expect_out(0, 0, "R8 after acknowledge");
    wr(0, 8);
    expect_out(0, 0, "R8 flag cleared after restore");

    // R9: held event fires once
    @(negedge clk); evt[61] = 1'b1;
    expect_out(1, 5, "R9 held event first edge");
    do_ack(); wr(0, 8);
    expect_out(0, 0, "R9 held event no refire");
    @(negedge clk); evt[61] = 1'b0;

    // R3: flag latched while disabled
    wr(1, 0);
    pulse_evt(61);
    expect_out(0, 0, "R3 disabled line silent");
    wr(1, 1 << 5);
    expect_out(1, 5, "R3 latched flag appears on enable");
    do_ack(); wr(0, 8);

    // R4 gating, R10 software set
    wr(0, 2); wr(2, 1 << 7); wr(1, 1 << 7);
    expect_out(0, 0, "R4 global enable off");
    wr(0, 1);
    expect_out(0, 0, "R4 nmi enable off");
    wr(0, 3);
    expect_out(1, 7, "R4 R10 all enables on");

    // R1 priority order
    wr(2, 16'h1010); wr(1, 16'h1090);
    expect_out(1, 4, "R1 lowest first");
    do_ack(); wr(0, 8);
    expect_out(1, 7, "R1 second");
    do_ack(); wr(0, 8);
    expect_out(1, 12, "R1 third");
    do_ack(); wr(0, 8);
    expect_out(0, 0, "R1 all served");

    // R10 clear register
    wr(2, 16'h0600); wr(1, 16'h0600); wr(3, 16'h0200);
    expect_out(1, 10, "R10 clear bit 9");
    wr(3, 0);
    expect_out(1, 10, "R10 zero clear no effect");
    wr(3, 16'h0400);
    expect_out(0, 0, "R10 clear bit 10");

    // R7 reserved
    wr(1, 16'hFFFF); wr(2, 16'h000C);
    expect_out(0, 0, "R7 reserved flags silent");
    wr(3, 16'h000C);

    // R5 non-maskable
    wr(1, 0); wr(0, 2);
    pulse_nmi();
    expect_out(1, 1, "R5 nmi without global enable");
    do_ack();
    expect_out(0, 0, "R5 nmi acknowledged");
    wr(0, 0);
    pulse_nmi();
    expect_out(0, 0, "R5 nmi blocked by nmi enable");
    wr(0, 2);
    expect_out(1, 1, "R5 latched nmi appears");
    do_ack();
    expect_out(0, 0, "R5 nmi cleared");

    // R6 reset position
    wr(0, 0);
    pulse_rst();
    expect_out(1, 0, "R6 reset ungated");
    do_ack();
    expect_out(0, 0, "R6 reset acknowledged");
    wr(1, 16'h0010); wr(2, 16'h0010); wr(0, 3);
    pulse_nmi(); pulse_rst();
    expect_out(1, 0, "R6 reset beats nmi and maskable");
    do_ack();
    expect_out(1, 1, "R5 nmi after reset served");
    do_ack();
    expect_out(0, 0, "R4 maskable held off after acknowledges");
    wr(0, 3);
    expect_out(1, 4, "R4 maskable after enable");
    do_ack(); wr(0, 3);

    // R2 selectors
    wr(6, 100); wr(1, 1 << 6);
    pulse_evt(100);
    expect_out(1, 6, "R2 event 100 on line 6");
    do_ack(); wr(0, 3);
    wr(15, 127); wr(1, 16'h8000);
    pulse_evt(127);
    expect_out(1, 15, "R2 event 127 on line 15");
    do_ack(); wr(0, 3);
    @(negedge clk); evt[20] = 1'b1;
    wr(8, 20); wr(1, 1 << 8);
    expect_out(0, 0, "R9 R2 already-high event not an edge");
    @(negedge clk); evt[20] = 1'b0;
    pulse_evt(20);
    expect_out(1, 8, "R2 event 20 on line 8");
    do_ack(); wr(0, 3);

    // R12 stray acknowledge
    wr(1, 0);
    do_ack();
    wr(1, 16'h0010); wr(2, 16'h0010);
    expect_out(1, 4, "R12 stray ack kept global enable");

    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule